// File: doc/BRIEF.md
# Dual-Field Residue Digit Modular Multiplier

This block multiplies two W-bit residue digits and reduces the product by the modulus of one residue channel. It serves both field types through one datapath. In integer mode the channel modulus is 2^W − μ. In polynomial mode the modulus is x^W + μ(x) over GF(2). In both cases μ is a small constant of at most MUW bits that comes with each operation.

The product comes from a tree of partial products, and both modes share the same tree. Each partial-product row is the AND of one operand with one bit of the other operand. Each adder node in the tree is a dual-field adder: its carries are masked off in polynomial mode, so the tree then gives a carry-less product.

Reduction uses the identity 2^W ≡ μ, or x^W ≡ μ(x) in polynomial mode. The high part is multiplied by μ on a smaller copy of the same dual-field multiplier and added back to the low part. This fold runs three times. In integer mode one conditional subtraction of the modulus then follows. Each operation carries its own mode and μ, so channels and fields can be mixed in consecutive cycles. The pipeline accepts one operation per cycle.

Top module: `dfr_modmul`

## Requirements
- R1: With `int_mode`=1, `result` equals (op_a · op_b) mod (2^W − mu), where the operands are unsigned integers.
- R2: With `int_mode`=0, bit i of an operand is the coefficient of x^i over GF(2). `result` is the carry-less product of op_a and op_b reduced modulo x^W + mu(x), with bit i again the coefficient of x^i.
- R3: With mu = 0, integer mode returns the low W bits of the integer product and polynomial mode returns the low W bits of the carry-less product.
- R4: In integer mode the result always lies in [0, 2^W − mu − 1], even for operands at or above the modulus, including both operands all ones. An operand equal to the modulus gives 0.
- R5: In polynomial mode the reduced value fits in W bits before the output stage, and no subtraction is applied to it.
- R6: `out_valid` is `in_valid` delayed by exactly 3 clock cycles. One operation can be issued every cycle, and each operation takes its own `int_mode` and `mu` from the cycle in which it is issued.
- R7: While `rst_n` is low, `out_valid` and `result` are 0. Operations in flight when reset is asserted never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| int_mode | input | 1 | 1 = integer modulus 2^W − mu, 0 = polynomial modulus x^W + mu(x) |
| mu | input | MUW | Small modulus constant of this operation |
| op_a | input | W | First residue digit |
| op_b | input | W | Second residue digit |
| out_valid | output | 1 | Result present this cycle |
| result | output | W | Reduced product |

## Verification
The bench targets the operands at the top of the integer range. With both operands all ones and the largest μ, a design that under-folds or skips the final subtraction returns a value at or above the modulus. An operand exactly equal to the modulus must give zero, and a comparison that is off by one shows up as the modulus itself.

Small polynomial operands such as 3·3 give 5 instead of 9, which exposes a carry that leaks into the tree. With μ = 0, a fold that adds garbage into the high bits becomes visible. Streaming ops back to back with the mode and μ changing every cycle catches any stage that pairs an operand with the wrong cycle's control. A reset taken with operations in flight catches a valid bit that survives the reset.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic {
    FIELD_POLY = 1'b0,
    FIELD_INT  = 1'b1
  } field_e;

  // output width of one fold: hi*mu (+) lo, one guard bit for the integer carry
  function automatic int dfr_fold_w(input int in_w, input int w, input int muw);
    int prod_w;
    prod_w = (in_w - w) + muw;
    return ((prod_w > w) ? prod_w : w) + 1;
  endfunction

endpackage

// File: rtl/dfr_dfadd.sv
// Dual-field adder: integer sum, or bitwise GF(2) sum when carries are masked.
module dfr_dfadd #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         int_mode,
  output logic [N-1:0] s
);
  logic [N-1:0] full;
  logic [N-1:0] carry_in;

  assign full     = x + y;
  // carry into each bit, recovered from the full sum, then gated by field
  assign carry_in = int_mode ? (full ^ x ^ y) : '0;
  assign s        = x ^ y ^ carry_in;
endmodule

// File: rtl/dfr_mult.sv
// Dual-field AW x BW multiplier: shared AND partial products, adder tree
// of dual-field adders laid out as a heap (leaves at BW-1 .. 2*BW-2).
module dfr_mult #(
  parameter int AW = 8,
  parameter int BW = 4
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  input  logic             int_mode,
  output logic [AW+BW-1:0] p
);
  localparam int PW    = AW + BW;
  localparam int NODES = 2 * BW - 1;

  logic [PW-1:0] node [NODES];

  for (genvar i = 0; i < BW; i++) begin : g_pp
    assign node[BW-1+i] = PW'(a & {AW{b[i]}}) << i;
  end

  for (genvar j = 0; j < BW - 1; j++) begin : g_tree
    dfr_dfadd #(.N(PW)) i_add (
      .x        (node[2*j+1]),
      .y        (node[2*j+2]),
      .int_mode (int_mode),
      .s        (node[j])
    );
  end

  assign p = node[0];
endmodule

// File: rtl/dfr_fold.sv
// One reduction fold: v = hi*mu (+) lo, using 2^W == mu (or x^W == mu(x)).
module dfr_fold #(
  parameter int IN_W = 16,
  parameter int W    = 8,
  parameter int MUW  = 3
) (
  input  logic [IN_W-1:0]                        v_in,
  input  logic [MUW-1:0]                         mu,
  input  logic                                   int_mode,
  output logic [dfr_pkg::dfr_fold_w(IN_W, W, MUW)-1:0] v_out
);
  localparam int HI_W   = IN_W - W;
  localparam int PROD_W = HI_W + MUW;
  localparam int OUT_W  = dfr_pkg::dfr_fold_w(IN_W, W, MUW);

  logic [HI_W-1:0]   hi;
  logic [W-1:0]      lo;
  logic [PROD_W-1:0] hi_mu;

  assign hi = v_in[IN_W-1:W];
  assign lo = v_in[W-1:0];

  dfr_mult #(.AW(HI_W), .BW(MUW)) i_hi_mul (
    .a        (hi),
    .b        (mu),
    .int_mode (int_mode),
    .p        (hi_mu)
  );

  dfr_dfadd #(.N(OUT_W)) i_fold_add (
    .x        (OUT_W'(hi_mu)),
    .y        (OUT_W'(lo)),
    .int_mode (int_mode),
    .s        (v_out)
  );
endmodule

// File: rtl/dfr_csub.sv
// Final step: one conditional subtraction of 2^W - mu in integer mode,
// pass-through of the low W bits in polynomial mode.
module dfr_csub #(
  parameter int W   = 8,
  parameter int MUW = 3
) (
  input  logic [W:0]     v_in,
  input  logic [MUW-1:0] mu,
  input  logic           int_mode,
  output logic [W-1:0]   r,
  output logic           sub_taken
);
  logic [W:0] modulus;
  logic [W:0] diff;

  assign modulus   = ((W+1)'(1) << W) - (W+1)'(mu);
  assign diff      = v_in - modulus;
  assign sub_taken = int_mode && (v_in >= modulus);
  assign r         = sub_taken ? W'(diff) : W'(v_in);
endmodule

// File: rtl/dfr_modmul.sv
// Three-stage dual-field residue digit modular multiplier.
//   stage 1: full product (integer or carry-less)
//   stage 2: two folds of the high part by mu
//   stage 3: last fold and conditional subtraction
module dfr_modmul #(
  parameter int W   = 32,
  parameter int MUW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           int_mode,
  input  logic [MUW-1:0] mu,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [W-1:0]   result
);
  import dfr_pkg::*;

  localparam int P_W  = 2 * W;
  localparam int F1_W = dfr_fold_w(P_W, W, MUW);
  localparam int F2_W = dfr_fold_w(F1_W, W, MUW);
  localparam int F3_W = dfr_fold_w(F2_W, W, MUW);

  // ---------------- stage 1: product ----------------
  logic [P_W-1:0] prod_c;
  logic [P_W-1:0] s1_prod;
  logic           s1_vld;
  field_e         s1_fld;
  logic [MUW-1:0] s1_mu;

  dfr_mult #(.AW(W), .BW(W)) i_core_mul (
    .a        (op_a),
    .b        (op_b),
    .int_mode (int_mode),
    .p        (prod_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_fld  <= FIELD_POLY;
      s1_mu   <= '0;
      s1_prod <= '0;
    end else begin
      s1_vld  <= in_valid;
      s1_fld  <= field_e'(int_mode);
      s1_mu   <= mu;
      s1_prod <= prod_c;
    end
  end

  // ---------------- stage 2: two folds ----------------
  logic           s1_int;
  logic [F1_W-1:0] fold1_v;
  logic [F2_W-1:0] fold2_v;
  logic [F2_W-1:0] s2_val;
  logic            s2_vld;
  field_e          s2_fld;
  logic [MUW-1:0]  s2_mu;

  assign s1_int = (s1_fld == FIELD_INT);

  dfr_fold #(.IN_W(P_W), .W(W), .MUW(MUW)) i_fold1 (
    .v_in     (s1_prod),
    .mu       (s1_mu),
    .int_mode (s1_int),
    .v_out    (fold1_v)
  );

  dfr_fold #(.IN_W(F1_W), .W(W), .MUW(MUW)) i_fold2 (
    .v_in     (fold1_v),
    .mu       (s1_mu),
    .int_mode (s1_int),
    .v_out    (fold2_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s2_fld <= FIELD_POLY;
      s2_mu  <= '0;
      s2_val <= '0;
    end else begin
      s2_vld <= s1_vld;
      s2_fld <= s1_fld;
      s2_mu  <= s1_mu;
      s2_val <= fold2_v;
    end
  end

  // ---------------- stage 3: last fold and subtraction ----------------
  logic            s2_int;
  logic [F3_W-1:0] fold3_v;
  logic [W-1:0]    final_c;
  logic            sub_taken;
  field_e          o_fld;
  logic [MUW-1:0]  o_mu;

  assign s2_int = (s2_fld == FIELD_INT);

  dfr_fold #(.IN_W(F2_W), .W(W), .MUW(MUW)) i_fold3 (
    .v_in     (s2_val),
    .mu       (s2_mu),
    .int_mode (s2_int),
    .v_out    (fold3_v)
  );

  dfr_csub #(.W(W), .MUW(MUW)) i_csub (
    .v_in      (fold3_v[W:0]),
    .mu        (s2_mu),
    .int_mode  (s2_int),
    .r         (final_c),
    .sub_taken (sub_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      o_fld     <= FIELD_POLY;
      o_mu      <= '0;
      result    <= '0;
    end else begin
      out_valid <= s2_vld;
      o_fld     <= s2_fld;
      o_mu      <= s2_mu;
      result    <= final_c;
    end
  end

  // ---------------- assertions ----------------
  logic [1:0]   age;
  logic [W+1:0] twice_mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign twice_mod = (((W+2)'(1) << W) - (W+2)'(s2_mu)) << 1;

  AST_CLMUL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_fld == FIELD_POLY) |-> (s1_prod[P_W-1] == 1'b0)); // R2

  AST_POLY_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_fld == FIELD_POLY) |-> (s2_val[F2_W-1:W] == '0 && !sub_taken)); // R5

  AST_ONE_SUB_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_fld == FIELD_INT) |-> ((W+2)'(fold3_v) < twice_mod)); // R4

  AST_INT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fld == FIELD_INT) |->
      ((W+1)'(result) < (((W+1)'(1) << W) - (W+1)'(o_mu)))); // R4

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && result == '0)); // R7

endmodule

// File: tb/test_dfr_modmul.sv
module test_dfr_modmul;
  localparam int  W      = 32;
  localparam int  MUW    = 10;
  localparam time PERIOD = 10ns;
  localparam int  NV     = 12;
  localparam int  NR     = 40;
  localparam int  NS     = NV + NR;

  localparam logic [W-1:0] TA [NV] = '{
    32'h12345678, 32'hFFFFFFFF, 32'hFFFFFC01, 32'hFFFFFC00, 32'hDEADBEEF, 32'h89ABCDEF,
    32'h80000000, 32'hFFFFFFFF, 32'h13579BDF, 32'h00000003, 32'h00000003, 32'h00000001};
  localparam logic [W-1:0] TB [NV] = '{
    32'h9ABCDEF0, 32'hFFFFFFFF, 32'h00001234, 32'hFFFFFC00, 32'h00000000, 32'hFEDCBA98,
    32'h80000000, 32'hFFFFFFFF, 32'h2468ACE0, 32'h00000003, 32'h00000003, 32'hC0FFEE11};
  localparam logic [MUW-1:0] TMU [NV] = '{
    10'd5, 10'h3FF, 10'h3FF, 10'h3FF, 10'd7, 10'd0,
    10'h08D, 10'h3FF, 10'd0, 10'd1, 10'd1, 10'h2BD};
  // 1 = integer mode, index 0 is the first vector
  localparam logic TF [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                               1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           int_mode = 1'b0;
  logic [MUW-1:0] mu = '0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           out_valid;
  logic [W-1:0]   result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0]   qa [NS];
  logic [W-1:0]   qb [NS];
  logic [MUW-1:0] qm [NS];
  logic           qf [NS];
  logic [W-1:0]   qe [NS];

  always #(PERIOD/2) clk = ~clk;

  dfr_modmul #(.W(W), .MUW(MUW)) i_dfr_modmul (
    .clk, .rst_n, .in_valid, .int_mode, .mu, .op_a, .op_b, .out_valid, .result
  );

  function automatic logic [W-1:0] ref_int(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [MUW-1:0] m);
    logic [63:0] p;
    logic [63:0] md;
    p  = {32'd0, a} * {32'd0, b};
    md = 64'h1_0000_0000 - {54'd0, m};
    return W'(p % md);
  endfunction

  // schoolbook carry-less product, then long division by x^32 + m(x)
  function automatic logic [W-1:0] ref_poly(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [MUW-1:0] m);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < W; i++) if (b[i]) p = p ^ ({32'd0, a} << i);
    for (int i = 2*W-1; i >= W; i--)
      if (p[i]) p = p ^ ((64'h1_0000_0000 | {54'd0, m}) << (i - W));
    return p[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // stream qa..qe back to back, one per cycle; result k seen 3 negedges later
  task automatic run_stream(input int n);
    for (int k = 0; k < n + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        chk(out_valid === 1'b1, "R6 valid in stream", W'(out_valid), W'(1));
        chk(result === qe[k-3],
            (qm[k-3] == '0) ? "R3 mu zero" : (qf[k-3] ? "R1,R4 integer" : "R2,R5 polynomial"),
            result, qe[k-3]);
      end
      if (k < n) begin
        in_valid = 1'b1; int_mode = qf[k]; mu = qm[k]; op_a = qa[k]; op_b = qb[k];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    logic [31:0] s;
    // R7: reset state
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R7 reset valid", W'(out_valid), W'(0));
    chk(result === '0, "R7 reset result", result, '0);
    rst_n = 1'b1;

    // table vectors followed by pseudo-random ones, mode and mu change per op
    s = 32'h2545F491;
    for (int k = 0; k < NS; k++) begin
      if (k < NV) begin
        qa[k] = TA[k]; qb[k] = TB[k]; qm[k] = TMU[k]; qf[k] = TF[k];
      end else begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); qa[k] = s;
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); qb[k] = s;
        qm[k] = s[MUW+3:4];
        qf[k] = s[1];
      end
      qe[k] = qf[k] ? ref_int(qa[k], qb[k], qm[k]) : ref_poly(qa[k], qb[k], qm[k]);
    end
    run_stream(NS);

    // R4: operand equal to modulus gives zero; R2: 3*3 carry-less is 5
    chk(ref_int(32'hFFFFFC01, 32'h1234, 10'h3FF) == '0, "R4 model zero", '0, '0);
    chk(qe[9] == 32'd5, "R2 model clmul", qe[9], 32'd5);

    // R6: single op, then idle: exactly one valid pulse, 3 cycles later
    @(negedge clk);
    in_valid = 1'b1; int_mode = 1'b1; mu = 10'd3; op_a = 32'd7; op_b = 32'd9;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b0, "R6 gap cycle 1", W'(out_valid), W'(0));
    @(negedge clk);
    chk(out_valid === 1'b0, "R6 gap cycle 2", W'(out_valid), W'(0));
    @(negedge clk);
    chk(out_valid === 1'b1, "R6 gap cycle 3", W'(out_valid), W'(1));
    chk(result === 32'd63, "R1 small integer", result, 32'd63);
    @(negedge clk);
    chk(out_valid === 1'b0, "R6 gap cycle 4", W'(out_valid), W'(0));

    // R7: reset with ops in flight flushes them
    in_valid = 1'b1; int_mode = 1'b0; mu = 10'd1; op_a = 32'hF0F0F0F0; op_b = 32'h0F0F0F0F;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(out_valid === 1'b0, "R7 reset in flight valid", W'(out_valid), W'(0));
    chk(result === '0, "R7 reset in flight result", result, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R7 flushed after reset", W'(out_valid), W'(0));
    end

    finish_run();
  end

  initial begin
    #(PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule